// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block produces the control-store address for a microprogrammed control unit. It keeps a micro program counter and, on every clock, chooses the next address from a small set of sources. It can load the start address of a new machine instruction's microroutine. It can return to the shared instruction-fetch routine when a microinstruction finishes its routine. It can jump to a branch target when a selected condition holds. Otherwise it steps to the following word. The branch target may have its least significant bit forced high by an addressing-mode indicator, so one target serves two routines that differ only by mode.

The chosen address goes to a small synchronous control store of horizontal control words. The store is filled with a computed test pattern so that a testbench can see it. The word is read while the current one is still driving the outputs. Both the micro program counter and its control word are therefore registered on the same edge and always appear together. The machine datapath, the opcode decode tables and main memory sit outside this block. The block receives the opcode-derived start address, the branch fields, the flags, the mode indicator and the end bit on its ports.

Top module: `microseq_core`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 (the fetch routine address) and `ctrl_word` holds the store word for address 0.
- R2: When `inst_load` is high at a rising edge, `upc` takes `start_addr` at that edge, whatever the other selection inputs are.
- R3: When `inst_load` is low and `end_bit` is high at a rising edge, `upc` becomes 0 at that edge, even if a branch would be taken.
- R4: When neither `inst_load` nor `end_bit` is high and the branch is taken, `upc` becomes `br_target`, with bit 0 ORed with `mode_ind`.
- R5: `br_sel` decides whether the branch is taken: 2'b00 never, 2'b01 always, 2'b10 when `flag_n` is 1, 2'b11 when `flag_z` is 1.
- R6: In every other case `upc` increments by one modulo 256, so 8'hFF is followed by 8'h00.
- R7: `mode_ind` acts only on a taken branch. On a target whose bit 0 is already 1 it changes nothing, and when no branch is taken it has no effect on `upc`.
- R8: `ctrl_word` always holds the store word for the current `upc`. For an address a below 16, bit j of that word is 1 exactly when (a + j) mod 3 is 0, so several bits are set at once. For a of 16 or more the word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_load | input | 1 | New machine instruction has been loaded |
| start_addr | input | 8 | Start address of the new instruction's microroutine |
| end_bit | input | 1 | Current microinstruction ends its routine |
| br_sel | input | 2 | Branch condition select |
| br_target | input | 8 | Branch target address |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| mode_ind | input | 1 | Addressing-mode indicator for the bit-OR step |
| upc | output | 8 | Registered micro program counter (control-store address) |
| ctrl_word | output | 16 | Prefetched horizontal control word for `upc` |

## Verification
Several next-address sources can request the counter in the same cycle: an instruction load together with an end bit or a taken branch, and an end bit together with an always-taken branch. The bench drives these pairs on purpose, each in a single cycle. A reference model applies the fixed priority and predicts the winner, and the registered address and its control word are compared with that prediction after the edge. The model also covers the increment wrap at 8'hFF and the bit-OR of the mode indicator on taken and untaken branches.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // Branch condition select encoding (fixed by the microinstruction format)
   typedef enum logic [1:0] {
      SEL_NEVER  = 2'b00,
      SEL_ALWAYS = 2'b01,
      SEL_NEG    = 2'b10,
      SEL_ZERO   = 2'b11
   } cond_sel_e;

   // Which source won the next-address choice
   typedef enum logic [1:0] {
      NXT_LOAD  = 2'd0,
      NXT_FETCH = 2'd1,
      NXT_JUMP  = 2'd2,
      NXT_STEP  = 2'd3
   } nxt_src_e;

endpackage

// File: rtl/useq_cond.sv
module useq_cond
   import useq_pkg::*;
(
   input  logic [1:0] sel,
   input  logic       flag_n,
   input  logic       flag_z,
   output logic       take
);

   cond_sel_e sel_e;

   assign sel_e = cond_sel_e'(sel);

   always_comb begin
      case (sel_e)
         SEL_NEVER:  take = 1'b0;
         SEL_ALWAYS: take = 1'b1;
         SEL_NEG:    take = flag_n;
         SEL_ZERO:   take = flag_z;
         default:    take = 1'b0;
      endcase
   end

endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int unsigned AW         = 8,
   parameter int unsigned FETCH_ADDR = 0,
   parameter bit          OR_EN      = 1'b1
) (
   input  logic [AW-1:0] upc,
   input  logic          inst_load,
   input  logic [AW-1:0] start_addr,
   input  logic          end_bit,
   input  logic          take,
   input  logic [AW-1:0] br_target,
   input  logic          mode_ind,
   output logic [AW-1:0] nxt_addr,
   output nxt_src_e      nxt_src
);

   localparam logic [AW-1:0] FETCH_VEC = AW'(FETCH_ADDR);
   localparam logic [AW-1:0] ONE_VEC   = AW'(1);

   logic [AW-1:0] jump_addr;

   // Bit-OR step on the branch target, present only when enabled
   generate
      if (OR_EN) begin : g_bit_or
         assign jump_addr = {br_target[AW-1:1], br_target[0] | mode_ind};
      end else begin : g_plain
         logic unused_mode;
         assign unused_mode = mode_ind;
         assign jump_addr   = br_target;
      end
   endgenerate

   // Fixed priority: load, end, taken branch, step
   always_comb begin
      if (inst_load)    nxt_src = NXT_LOAD;
      else if (end_bit) nxt_src = NXT_FETCH;
      else if (take)    nxt_src = NXT_JUMP;
      else              nxt_src = NXT_STEP;
   end

   always_comb begin
      case (nxt_src)
         NXT_LOAD:  nxt_addr = start_addr;
         NXT_FETCH: nxt_addr = FETCH_VEC;
         NXT_JUMP:  nxt_addr = jump_addr;
         default:   nxt_addr = upc + ONE_VEC;
      endcase
   end

endmodule

// File: rtl/useq_store.sv
module useq_store #(
   parameter int unsigned AW       = 8,
   parameter int unsigned CW_W     = 16,
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned RST_ADDR = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   rd_addr,
   output logic [CW_W-1:0] cw_q
);

   localparam int unsigned IW = $clog2(DEPTH);
   localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

   // Test pattern: bit j of word a is set when (a + j) mod 3 == 0
   function automatic logic [CW_W-1:0] word_at(int unsigned a);
      logic [CW_W-1:0] w;
      w = '0;
      if (a < DEPTH) begin
         for (int unsigned j = 0; j < CW_W; j++) begin
            w[j] = ((a + j) % 3) == 0;
         end
      end
      return w;
   endfunction

   localparam logic [CW_W-1:0] RST_WORD = word_at(RST_ADDR);

   logic [CW_W-1:0] rom_w [DEPTH];
   logic            in_range;
   logic [IW-1:0]   idx;
   logic [CW_W-1:0] rd_word;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_rom
         assign rom_w[i] = word_at(i);
      end
   endgenerate

   assign in_range = {1'b0, rd_addr} < LIMIT;
   assign idx      = rd_addr[IW-1:0];
   assign rd_word  = in_range ? rom_w[idx] : '0;

   // Synchronous read: the prefetched word lands with its address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cw_q <= RST_WORD;
      else        cw_q <= rd_word;
   end

endmodule

// File: rtl/microseq_core.sv
module microseq_core
   import useq_pkg::*;
#(
   parameter int unsigned AW         = 8,
   parameter int unsigned CW_W       = 16,
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned FETCH_ADDR = 0,
   parameter bit          OR_EN      = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inst_load,
   input  logic [AW-1:0]   start_addr,
   input  logic            end_bit,
   input  logic [1:0]      br_sel,
   input  logic [AW-1:0]   br_target,
   input  logic            flag_n,
   input  logic            flag_z,
   input  logic            mode_ind,
   output logic [AW-1:0]   upc,
   output logic [CW_W-1:0] ctrl_word
);

   localparam logic [AW-1:0] FETCH_VEC = AW'(FETCH_ADDR);

   // Elaboration-time parameter checks
   generate
      if (AW < 2 || AW > 16) begin : g_bad_aw
         $error("microseq_core: AW out of range");
      end
      if (DEPTH < 2 || DEPTH > (1 << AW)) begin : g_bad_depth
         $error("microseq_core: DEPTH must be 2..2**AW");
      end
      if (FETCH_ADDR >= (1 << AW)) begin : g_bad_fetch
         $error("microseq_core: FETCH_ADDR outside address space");
      end
      if (CW_W < 1) begin : g_bad_cw
         $error("microseq_core: CW_W must be positive");
      end
   endgenerate

   logic          take;
   logic [AW-1:0] nxt_addr;
   nxt_src_e      nxt_src;

   useq_cond u_cond (
      .sel    (br_sel),
      .flag_n (flag_n),
      .flag_z (flag_z),
      .take   (take)
   );

   useq_next #(
      .AW         (AW),
      .FETCH_ADDR (FETCH_ADDR),
      .OR_EN      (OR_EN)
   ) u_next (
      .upc        (upc),
      .inst_load  (inst_load),
      .start_addr (start_addr),
      .end_bit    (end_bit),
      .take       (take),
      .br_target  (br_target),
      .mode_ind   (mode_ind),
      .nxt_addr   (nxt_addr),
      .nxt_src    (nxt_src)
   );

   logic unused_src;
   assign unused_src = ^nxt_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= FETCH_VEC;
      else        upc <= nxt_addr;
   end

   useq_store #(
      .AW       (AW),
      .CW_W     (CW_W),
      .DEPTH    (DEPTH),
      .RST_ADDR (FETCH_ADDR)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (nxt_addr),
      .cw_q    (ctrl_word)
   );

endmodule

// File: rtl/microseq_core_chk.sv
module microseq_core_chk #(
   parameter int unsigned AW         = 8,
   parameter int unsigned CW_W       = 16,
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned FETCH_ADDR = 0,
   parameter bit          OR_EN      = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            inst_load,
   input logic [AW-1:0]   start_addr,
   input logic            end_bit,
   input logic [1:0]      br_sel,
   input logic [AW-1:0]   br_target,
   input logic            flag_n,
   input logic            flag_z,
   input logic            mode_ind,
   input logic [AW-1:0]   upc,
   input logic [CW_W-1:0] ctrl_word
);

   logic [AW-1:0] jump_exp;
   assign jump_exp = br_target | AW'(mode_ind & OR_EN);

   // R1
   reset_fetch_chk: assert property (@(posedge clk) !rst_n |=> (!rst_n -> upc == AW'(FETCH_ADDR)));

   // R2
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inst_load |=> upc == $past(start_addr));

   // R3
   end_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inst_load && end_bit) |=> upc == AW'(FETCH_ADDR));

   // R4
   jump_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inst_load && !end_bit && br_sel == 2'b01) |=> upc == $past(jump_exp));

   // R5
   never_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inst_load && !end_bit && br_sel == 2'b00) |=> upc == AW'($past(upc) + 1'b1));

   // R6
   flag_clear_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inst_load && !end_bit && ((br_sel == 2'b10 && !flag_n) || (br_sel == 2'b11 && !flag_z)))
      |=> upc == AW'($past(upc) + 1'b1));

   // R8
   blank_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, upc} >= (AW+1)'(DEPTH)) |-> ctrl_word == '0);

endmodule

bind microseq_core microseq_core_chk #(
   .AW(AW), .CW_W(CW_W), .DEPTH(DEPTH), .FETCH_ADDR(FETCH_ADDR), .OR_EN(OR_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .inst_load(inst_load), .start_addr(start_addr),
   .end_bit(end_bit), .br_sel(br_sel), .br_target(br_target), .flag_n(flag_n),
   .flag_z(flag_z), .mode_ind(mode_ind), .upc(upc), .ctrl_word(ctrl_word)
);

// File: tb/microseq_core_test.sv
module microseq_core_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        inst_load;
   logic [7:0]  start_addr;
   logic        end_bit;
   logic [1:0]  br_sel;
   logic [7:0]  br_target;
   logic        flag_n;
   logic        flag_z;
   logic        mode_ind;
   logic [7:0]  upc;
   logic [15:0] ctrl_word;

   int tests  = 0;
   int failed = 0;
   int model  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   microseq_core uut (
      .clk(clk), .rst_n(rst_n), .inst_load(inst_load), .start_addr(start_addr),
      .end_bit(end_bit), .br_sel(br_sel), .br_target(br_target),
      .flag_n(flag_n), .flag_z(flag_z), .mode_ind(mode_ind),
      .upc(upc), .ctrl_word(ctrl_word)
   );

   // Expected store word per R8
   function automatic logic [15:0] ref_word(int a);
      logic [15:0] w = '0;
      if (a < 16)
         for (int j = 0; j < 16; j++)
            if ((a + j) % 3 == 0) w[j] = 1'b1;
      return w;
   endfunction

   task automatic compare(input string tag);
      tests++;
      if (upc !== 8'(model) || ctrl_word !== ref_word(model)) begin
         failed++;
         $display("FAIL %s: upc=%02h word=%04h expected upc=%02h word=%04h",
                  tag, upc, ctrl_word, 8'(model), ref_word(model));
      end
   endtask

   // One clock: drive at negedge, predict, sample at next negedge
   task automatic step(input logic ld, input logic [7:0] sa, input logic en,
                       input logic [1:0] sel, input logic [7:0] tgt,
                       input logic n, input logic z, input logic md,
                       input string tag);
      bit tk;
      inst_load = ld; start_addr = sa; end_bit = en; br_sel = sel;
      br_target = tgt; flag_n = n; flag_z = z; mode_ind = md;
      tk = (sel == 2'd1) || (sel == 2'd2 && n) || (sel == 2'd3 && z);
      if (ld)      model = sa;
      else if (en) model = 0;
      else if (tk) model = tgt | {7'd0, md};
      else         model = (model + 1) % 256;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic hold_reset();
      rst_n = 1'b0;
      model = 0;
      @(negedge clk);
      compare("R1 reset");
      @(negedge clk);
      compare("R1 reset held");
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; inst_load = 0; start_addr = 0; end_bit = 0; br_sel = 0;
      br_target = 0; flag_n = 0; flag_z = 0; mode_ind = 0;
      @(negedge clk);
      hold_reset();
      // R6 plain increments, R7 mode ignored when no branch
      step(0, 8'h00, 0, 2'b00, 8'h80, 0, 0, 0, "R6 step");
      step(0, 8'h00, 0, 2'b00, 8'h80, 1, 1, 1, "R7 mode no branch");
      step(0, 8'h00, 0, 2'b00, 8'h80, 0, 0, 0, "R6 step");
      // R2 load then wrap (R6)
      step(1, 8'hFD, 0, 2'b00, 8'h00, 0, 0, 0, "R2 load");
      step(0, 8'h00, 0, 2'b00, 8'h00, 0, 0, 0, "R6 step FE");
      step(0, 8'h00, 0, 2'b00, 8'h00, 0, 0, 0, "R6 step FF");
      step(0, 8'h00, 0, 2'b00, 8'h00, 0, 0, 0, "R6 wrap");
      // R4/R5 conditions
      step(0, 8'h00, 0, 2'b01, 8'h0A, 0, 0, 0, "R4 always");
      step(0, 8'h00, 0, 2'b01, 8'h40, 0, 0, 1, "R7 or lsb");
      step(0, 8'h00, 0, 2'b01, 8'h05, 0, 0, 1, "R7 lsb already set");
      step(0, 8'h00, 0, 2'b10, 8'h20, 0, 1, 0, "R5 neg clear");
      step(0, 8'h00, 0, 2'b10, 8'h20, 1, 0, 0, "R5 neg set");
      step(0, 8'h00, 0, 2'b11, 8'h30, 1, 0, 1, "R5 zero clear");
      step(0, 8'h00, 0, 2'b11, 8'h0C, 0, 1, 1, "R5 zero set");
      step(0, 8'h00, 0, 2'b00, 8'h90, 1, 1, 1, "R5 never");
      // R3 end, and collisions
      step(0, 8'h00, 1, 2'b00, 8'h00, 0, 0, 0, "R3 end");
      step(0, 8'h00, 0, 2'b00, 8'h00, 0, 0, 0, "R6 after end");
      step(0, 8'h00, 1, 2'b01, 8'h77, 0, 0, 1, "R3 end beats branch");
      step(1, 8'h0E, 1, 2'b01, 8'h55, 0, 0, 0, "R2 load beats end");
      step(1, 8'h21, 0, 2'b01, 8'h06, 0, 0, 1, "R2 load beats branch");
      step(0, 8'h00, 0, 2'b00, 8'h00, 0, 0, 0, "R8 beyond store");
      step(1, 8'h0F, 0, 2'b00, 8'h00, 0, 0, 0, "R8 last word");
      step(0, 8'h00, 0, 2'b00, 8'h00, 0, 0, 0, "R8 first blank");
      // R1 reset mid-run
      @(negedge clk);
      model = (model + 1) % 256;
      compare("R6 idle");
      hold_reset();
      step(0, 8'h00, 0, 2'b00, 8'h00, 0, 0, 0, "R6 after reset");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         failed++;
         tests++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, failed);
         $finish;
      end
   end

endmodule